// File: doc/BRIEF.md
# Three-Channel Interval Timer with Speaker Gate

This block holds three 16-bit down-counters behind a byte-wide register bus with four addresses. The first three addresses move count bytes in and out of channels 0, 1 and 2. The fourth address is a write-only command register that configures one channel at a time or freezes a channel's count for reading. All channels advance on a shared count strobe, `cnt_tick`, which runs at the slow counter rate. It is nominally 1.193 MHz, so a channel-0 reload of 65536 gives about 18.2 ticks per second.

Channel 0 sends a one-cycle request to interrupt level 0 each time its output rises. Channels 0 and 1 always have their gates enabled. A separate control port holds the gate of channel 2 and a speaker enable. The speaker line follows channel 2's output only while the enable is set. The same port reads back channel 2's live output level. Two operating modes are built: a one-shot event count (mode 0) and a square wave (mode 3). Both count in binary. A command that asks for any other mode or for decimal counting is refused.

Top module: `interval_timer3`

## Requirements
- R1: After reset, `spk_out`, `irq0_req`, `aux_rdata` and `bus_rdata` are all zero.
- R2: A command byte at address 3 is decoded as follows: bits 7:6 select the channel, bits 5:4 select the access mode, bits 3:1 select the operating mode, and bit 0 selects decimal counting. A command is refused, and leaves the target channel's setup, counting and output untouched, in any of these cases: the channel field is 3; the access field is nonzero and bit 0 is 1; the access field is nonzero and bits 3:1 are neither 000 nor 011.
- R3: The access field selects how count bytes move. Code 01 moves the low byte only, with the high byte taken as zero. Code 10 moves the high byte only, with the low byte taken as zero. Code 11 moves the low byte first and then the high byte. A written count does not take effect, and the channel does not count, until the last byte of that sequence has arrived.
- R4: In mode 0, the output goes low when a count N is loaded. It goes high on the Nth strobe after the load and then stays high while the counter keeps decrementing. N = 0 means 65536.
- R5: In mode 3 with reload N, the output repeats a high phase of ceil(N/2) strobes followed by a low phase of floor(N/2) strobes, starting high at the load. N = 0 means 65536. N = 1 keeps the output high.
- R6: An access code of 00 freezes the channel's current count. Reads then return the frozen value in the channel's byte order while counting carries on. The count is released once the full byte sequence has been read, and later reads return the live count.
- R7: The gate of channel 2 is control-port bit 0. In mode 3, a low gate stops counting and drives the output high within one clock, and a rising gate restarts a full high phase. In mode 0, a low gate holds the count.
- R8: `spk_out` is high only while channel 2's output and control-port bit 1 are both high. `aux_rdata` shows bit 0 = gate, bit 1 = speaker enable and bit 5 = channel 2's output, with every other bit zero.
- R9: `irq0_req` is high for exactly one clock after each rising edge of channel 0's output. It therefore fires once per period in mode 3 and once per load in mode 0.
- R10: A read of address 3 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Counter strobe, one clock wide per count |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; data appears on `bus_rdata` after the next edge |
| bus_addr | input | 2 | Register address: 0 to 2 for the channels, 3 for the command register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| aux_we | input | 1 | Control-port write strobe |
| aux_wdata | input | 8 | Control-port write data (bit 0 gate, bit 1 speaker enable) |
| aux_rdata | output | 8 | Control-port readback with channel 2's output in bit 5 |
| irq0_req | output | 1 | One-clock interrupt request from channel 0 |
| spk_out | output | 1 | Speaker drive |

## Verification
The hardest situation to reach is a gate drop and restore on channel 2 in the middle of a running square wave. The phase lengths seen after the gate rises must match a fresh high phase, not the phase that was cut short. The stimulus runs the strobe continuously, lowers the gate partway through a wave, holds it for twenty clocks while sampling the speaker, and then raises it. A run-length monitor compares every later high and low phase against queued expectations. A second hard case is a frozen count read while the counter keeps moving. The bench freezes the count, issues further strobes, and expects the old value first and the live value afterwards.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int CNT_W      = 16;
  localparam int BYTE_W     = CNT_W / 2;
  localparam int REG_ADDR_W = 2;
  localparam int AUX_GATE_BIT = 0;
  localparam int AUX_SPK_BIT  = 1;
  localparam int AUX_OUT_BIT  = 5;

  typedef enum logic [1:0] {
    ACC_FREEZE = 2'b00,
    ACC_LO     = 2'b01,
    ACC_HI     = 2'b10,
    ACC_PAIR   = 2'b11
  } acc_e;

  localparam logic [CNT_W:0] ONE_X = {{CNT_W{1'b0}}, 1'b1};

  // full cycle length; a zero reload stands for the largest count
  function automatic logic [CNT_W:0] full_len(input logic [CNT_W-1:0] n);
    return (n == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, n};
  endfunction

  // high phase of a square wave: rounded up half of the cycle
  function automatic logic [CNT_W-1:0] phase_high(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] h;
    h = (full_len(n) + ONE_X) >> 1;
    return h[CNT_W-1:0];
  endfunction

  // low phase of a square wave: rounded down half of the cycle
  function automatic logic [CNT_W-1:0] phase_low(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] h;
    h = full_len(n) >> 1;
    return h[CNT_W-1:0];
  endfunction

  // only binary event count (000) and square wave (011) are built
  function automatic logic cmd_supported(input logic [7:0] c);
    return !c[0] && (c[3:1] == 3'd0 || c[3:1] == 3'd3);
  endfunction
endpackage

// File: rtl/itmr_channel.sv
module itmr_channel
  import itmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              gate,
  input  logic              cmd_we,
  input  logic              cmd_square,
  input  logic [1:0]        cmd_acc,
  input  logic              freeze_req,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              out,
  output logic              square,
  output logic              load_ev
);
  logic              sq_q;
  acc_e              acc_q;
  logic [CNT_W-1:0]  cnt_q, reload_q, frz_q;
  logic              armed_q, out_q, wr_hi_q, rd_hi_q, frozen_q, gate_d_q;
  logic [BYTE_W-1:0] lo_stage_q;
  logic [CNT_W-1:0]  new_n, src, run_hi, run_lo;

  always_comb begin
    unique case (acc_q)
      ACC_LO:  new_n = {{BYTE_W{1'b0}}, wdata};
      ACC_HI:  new_n = {wdata, {BYTE_W{1'b0}}};
      default: new_n = {wdata, lo_stage_q};
    endcase
    load_ev = wr_en && (acc_q != ACC_PAIR || wr_hi_q);
    run_hi  = phase_high(reload_q);
    run_lo  = phase_low(reload_q);
    src     = frozen_q ? frz_q : cnt_q;
    unique case (acc_q)
      ACC_LO:  rd_byte = src[BYTE_W-1:0];
      ACC_HI:  rd_byte = src[CNT_W-1:BYTE_W];
      default: rd_byte = rd_hi_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
    endcase
  end

  // setup, loading and counting
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_q       <= 1'b0;
      acc_q      <= ACC_PAIR;
      cnt_q      <= '0;
      reload_q   <= '0;
      armed_q    <= 1'b0;
      out_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      lo_stage_q <= '0;
      gate_d_q   <= 1'b1;
    end else begin
      gate_d_q <= gate;
      if (cmd_we) begin
        sq_q    <= cmd_square;
        acc_q   <= acc_e'(cmd_acc);
        armed_q <= 1'b0;
        out_q   <= cmd_square;
        wr_hi_q <= 1'b0;
      end else if (load_ev) begin
        reload_q <= new_n;
        armed_q  <= 1'b1;
        wr_hi_q  <= 1'b0;
        if (sq_q) begin
          cnt_q <= phase_high(new_n);
          out_q <= 1'b1;
        end else begin
          cnt_q <= new_n;
          out_q <= 1'b0;
        end
      end else begin
        if (wr_en) begin
          lo_stage_q <= wdata;
          wr_hi_q    <= 1'b1;
        end
        if (armed_q) begin
          if (sq_q) begin
            if (!gate) begin
              out_q <= 1'b1;
            end else if (!gate_d_q) begin
              cnt_q <= run_hi;
              out_q <= 1'b1;
            end else if (tick) begin
              if (cnt_q == CNT_W'(1)) begin
                if (out_q && run_lo != '0) begin
                  out_q <= 1'b0;
                  cnt_q <= run_lo;
                end else begin
                  out_q <= 1'b1;
                  cnt_q <= run_hi;
                end
              end else begin
                cnt_q <= cnt_q - 1'b1;
              end
            end
          end else if (gate && tick) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) out_q <= 1'b1;
          end
        end
      end
    end
  end

  // readout path: freeze and byte order
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_hi_q  <= 1'b0;
      frozen_q <= 1'b0;
      frz_q    <= '0;
    end else if (cmd_we) begin
      rd_hi_q  <= 1'b0;
      frozen_q <= 1'b0;
    end else if (freeze_req && !frozen_q) begin
      frozen_q <= 1'b1;
      frz_q    <= cnt_q;
    end else if (rd_en) begin
      if (acc_q == ACC_PAIR && !rd_hi_q) begin
        rd_hi_q <= 1'b1;
      end else begin
        rd_hi_q  <= 1'b0;
        frozen_q <= 1'b0;
      end
    end
  end

  assign out    = out_q;
  assign square = sq_q;
endmodule

// File: rtl/itmr_aux.sv
module itmr_aux
  import itmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       ch_out,
  output logic       gate,
  output logic       spk_out,
  output logic [7:0] rdata
);
  logic gate_q, spk_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      spk_en_q <= 1'b0;
    end else if (we) begin
      gate_q   <= wdata[AUX_GATE_BIT];
      spk_en_q <= wdata[AUX_SPK_BIT];
    end
  end

  always_comb begin
    rdata               = '0;
    rdata[AUX_GATE_BIT] = gate_q;
    rdata[AUX_SPK_BIT]  = spk_en_q;
    rdata[AUX_OUT_BIT]  = ch_out;
  end

  assign gate    = gate_q;
  assign spk_out = ch_out & spk_en_q;
endmodule

// File: rtl/interval_timer3.sv
module interval_timer3
  import itmr_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int SPK_CH = 2,
  parameter int IRQ_CH = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cnt_tick,
  input  logic                  bus_we,
  input  logic                  bus_re,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic                  aux_we,
  input  logic [7:0]            aux_wdata,
  output logic [7:0]            aux_rdata,
  output logic                  irq0_req,
  output logic                  spk_out
);
  localparam logic [REG_ADDR_W-1:0] CMD_ADDR = REG_ADDR_W'(NCH);

  logic                         cmd_wr, cmd_unsup, cmd_ok;
  logic [1:0]                   cmd_sel, cmd_acc;
  logic [NCH-1:0]               ch_out, ch_square, ch_load;
  logic [NCH-1:0][BYTE_W-1:0]   ch_rd_byte;
  logic                         spk_gate, out0_d_q;

  assign cmd_wr    = bus_we && (bus_addr == CMD_ADDR);
  assign cmd_sel   = bus_wdata[7:6];
  assign cmd_acc   = bus_wdata[5:4];
  assign cmd_ok    = cmd_supported(bus_wdata);
  assign cmd_unsup = cmd_wr && (int'(cmd_sel) >= NCH || (cmd_acc != 2'b00 && !cmd_ok));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = cmd_wr && (int'(cmd_sel) == i);
    itmr_channel u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (cnt_tick),
      .gate       ((i == SPK_CH) ? spk_gate : 1'b1),
      .cmd_we     (hit && cmd_acc != 2'b00 && cmd_ok),
      .cmd_square (bus_wdata[2]),
      .cmd_acc    (cmd_acc),
      .freeze_req (hit && cmd_acc == 2'b00),
      .wr_en      (bus_we && bus_addr == REG_ADDR_W'(i)),
      .wdata      (bus_wdata),
      .rd_en      (bus_re && bus_addr == REG_ADDR_W'(i)),
      .rd_byte    (ch_rd_byte[i]),
      .out        (ch_out[i]),
      .square     (ch_square[i]),
      .load_ev    (ch_load[i])
    );
  end

  itmr_aux u_aux (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (aux_we),
    .wdata   (aux_wdata),
    .ch_out  (ch_out[SPK_CH]),
    .gate    (spk_gate),
    .spk_out (spk_out),
    .rdata   (aux_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      out0_d_q  <= 1'b0;
    end else begin
      out0_d_q <= ch_out[IRQ_CH];
      if (bus_re) begin
        bus_rdata <= (int'(bus_addr) < NCH) ? ch_rd_byte[bus_addr] : 8'hFF;
      end
    end
  end

  assign irq0_req = ch_out[IRQ_CH] & ~out0_d_q;
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
  parameter int NCH    = 3,
  parameter int SPK_CH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ch_out,
  input logic [NCH-1:0] ch_square,
  input logic [NCH-1:0] ch_load,
  input logic           cmd_any,
  input logic           cmd_unsup,
  input logic           gate,
  input logic           spk_out,
  input logic [7:0]     aux_rdata,
  input logic           irq
);
  assert_unsup_keeps_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_unsup |=> $stable(ch_square));

  assert_event_load_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_load[1] && !ch_square[1]) |=> !ch_out[1]);

  assert_square_load_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_load[0] && ch_square[0]) |=> ch_out[0]);

  assert_gate_low_forces_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_square[SPK_CH] && !gate && !cmd_any) |=> ch_out[SPK_CH]);

  assert_spk_needs_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spk_out |-> (aux_rdata[5] && aux_rdata[1]));

  assert_irq_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

bind interval_timer3 itmr_checker #(.NCH(NCH), .SPK_CH(SPK_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_out    (ch_out),
  .ch_square (ch_square),
  .ch_load   (ch_load),
  .cmd_any   (cmd_wr),
  .cmd_unsup (cmd_unsup),
  .gate      (spk_gate),
  .spk_out   (spk_out),
  .aux_rdata (aux_rdata),
  .irq       (irq0_req)
);

// File: tb/test_interval_timer3.sv
`timescale 1ns/1ps
module test_interval_timer3;
  logic clk = 1'b0, rst_n = 1'b0, tk = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0, aux_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, aux_wdata = '0, bus_rdata, aux_rdata;
  logic irq0_req, spk_out;

  interval_timer3 i_interval_timer3 (
    .clk(clk), .rst_n(rst_n), .cnt_tick(tk), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .aux_we(aux_we), .aux_wdata(aux_wdata), .aux_rdata(aux_rdata),
    .irq0_req(irq0_req), .spk_out(spk_out)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, irq_cnt = 0;
  bit done = 0;

  typedef struct { logic lvl; int len; string tag; } run_t;
  run_t exp_q[$];
  bit mon_on = 0, mon_armed = 0, mon_started = 0;
  logic mon_prev = 1'b0;
  int run_len = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_re = 1; bus_addr = a;
    @(negedge clk); bus_re = 0; d = bus_rdata;
  endtask

  task automatic rd16(input logic [1:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a, hi); v = {hi, lo};
  endtask

  task automatic aux(input logic [7:0] d);
    @(negedge clk); aux_we = 1; aux_wdata = d;
    @(negedge clk); aux_we = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tk = 1; end
    @(negedge clk); tk = 0;
  endtask

  task automatic push_run(input logic l, input int n, input string t);
    run_t r; r.lvl = l; r.len = n; r.tag = t; exp_q.push_back(r);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    mon_on = 0;
  endtask

  // interrupt pulses counted where the request is stable
  always @(posedge clk) if (rst_n && irq0_req) irq_cnt++;

  // scoreboard monitor: measures speaker run lengths
  always @(negedge clk) begin
    if (!mon_on) begin
      mon_armed = 0; mon_started = 0;
    end else if (!mon_armed) begin
      mon_armed = 1; mon_prev = spk_out;
    end else if (spk_out !== mon_prev) begin
      if (mon_started && exp_q.size() > 0) begin
        run_t e;
        e = exp_q.pop_front();
        chk(run_len == e.len && mon_prev == e.lvl, e.tag, run_len, e.len);
      end
      mon_started = 1; run_len = 1; mon_prev = spk_out;
    end else begin
      run_len++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired (all requirements)");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    int c0, flips;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(spk_out == 0, "R1 spk", spk_out, 0);
    chk(irq0_req == 0, "R1 irq", irq0_req, 0);
    chk(aux_rdata == 8'h00, "R1 aux", aux_rdata, 0);
    chk(bus_rdata == 8'h00, "R1 rdata", bus_rdata, 0);
    // R10 command address reads all ones
    rd(2'd3, b); chk(b == 8'hFF, "R10 cmd read", b, 8'hFF);

    // R3/R4/R9 channel 0 event count, pair access
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h03);
    ticks(10); repeat (2) @(negedge clk);
    chk(irq_cnt == 0, "R3 half-written count idle", irq_cnt, 0);
    wr(2'd0, 8'h00);
    ticks(2); repeat (2) @(negedge clk);
    chk(irq_cnt == 0, "R4 before terminal", irq_cnt, 0);
    ticks(1); repeat (2) @(negedge clk);
    chk(irq_cnt == 1, "R4 R9 terminal pulse", irq_cnt, 1);
    ticks(10); repeat (2) @(negedge clk);
    chk(irq_cnt == 1, "R4 stays high", irq_cnt, 1);
    rd16(2'd0, v); chk(v == 16'hFFF6, "R4 keeps decrementing", v, 16'hFFF6);

    // R3 single-byte access modes on channel 1
    wr(2'd3, 8'h50); wr(2'd1, 8'h34);
    wr(2'd3, 8'h40); rd(2'd1, b);
    chk(b == 8'h34, "R3 low-only", b, 8'h34);
    wr(2'd3, 8'h60); wr(2'd1, 8'h12); rd(2'd1, b);
    chk(b == 8'h12, "R3 high-only", b, 8'h12);
    wr(2'd3, 8'h70); wr(2'd1, 8'hCD); wr(2'd1, 8'hAB);
    rd16(2'd1, v); chk(v == 16'hABCD, "R3 pair order", v, 16'hABCD);

    // R6 freeze while counting
    wr(2'd3, 8'h70); wr(2'd1, 8'h00); wr(2'd1, 8'h00);
    ticks(3);
    wr(2'd3, 8'h40);
    ticks(5);
    rd16(2'd1, v); chk(v == 16'hFFFD, "R6 frozen value", v, 16'hFFFD);
    rd16(2'd1, v); chk(v == 16'hFFF8, "R6 released live", v, 16'hFFF8);

    // R2 refused commands leave channel 1 counting
    wr(2'd3, 8'h74); wr(2'd3, 8'h71); wr(2'd3, 8'hF0);
    ticks(2);
    rd16(2'd1, v); chk(v == 16'hFFF6, "R2 refused commands", v, 16'hFFF6);

    // R5 square wave, N = 7
    aux(8'h03);
    wr(2'd3, 8'hB6); wr(2'd2, 8'h07); wr(2'd2, 8'h00);
    push_run(0, 3, "R5 N7 low"); push_run(1, 4, "R5 N7 high");
    push_run(0, 3, "R5 N7 low"); push_run(1, 4, "R5 N7 high");
    mon_on = 1; tk = 1;
    drain();

    // R7 gate low forces high, rising gate restarts
    aux(8'h02);
    @(negedge clk);
    flips = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (spk_out !== 1'b1) flips++; end
    chk(flips == 0, "R7 gate low holds high", flips, 0);
    push_run(0, 3, "R7 restart low"); push_run(1, 4, "R7 restart high");
    mon_on = 1;
    aux(8'h03);
    drain();

    // R5 N = 6
    @(negedge clk); tk = 0;
    wr(2'd2, 8'h06); wr(2'd2, 8'h00);
    push_run(0, 3, "R5 N6 low"); push_run(1, 3, "R5 N6 high"); push_run(0, 3, "R5 N6 low");
    mon_on = 1; tk = 1;
    drain();

    // R5 N = 1 stays high
    @(negedge clk); tk = 0;
    wr(2'd2, 8'h01); wr(2'd2, 8'h00);
    tk = 1; @(negedge clk);
    prev = spk_out; flips = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (spk_out !== prev) flips++; prev = spk_out; end
    chk(flips == 0 && spk_out == 1, "R5 N1 steady", flips, 0);

    // R8 speaker enable and readback
    aux(8'h01);
    chk(aux_rdata == 8'h21, "R8 aux readback off", aux_rdata, 8'h21);
    chk(spk_out == 0, "R8 speaker muted", spk_out, 0);
    aux(8'h03);
    chk(aux_rdata == 8'h23, "R8 aux readback on", aux_rdata, 8'h23);
    chk(spk_out == 1, "R8 speaker on", spk_out, 1);

    // R9 periodic interrupt, channel 0 square wave N = 4
    wr(2'd3, 8'h36); wr(2'd0, 8'h04); wr(2'd0, 8'h00);
    repeat (8) @(negedge clk);
    c0 = irq_cnt;
    repeat (40) @(negedge clk);
    chk(irq_cnt - c0 == 10, "R9 one pulse per period", irq_cnt - c0, 10);

    // R7 event count holds with gate low on channel 2
    @(negedge clk); tk = 0;
    wr(2'd3, 8'hB0); wr(2'd2, 8'h0A); wr(2'd2, 8'h00);
    aux(8'h00);
    ticks(5);
    wr(2'd3, 8'h80); rd16(2'd2, v);
    chk(v == 16'h000A, "R7 gate low holds count", v, 16'h000A);
    aux(8'h01);
    ticks(3);
    wr(2'd3, 8'h80); rd16(2'd2, v);
    chk(v == 16'h0007, "R7 gate high counts", v, 16'h0007);
    chk(aux_rdata == 8'h01, "R8 aux shows low output", aux_rdata, 8'h01);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule